// File: doc/BRIEF.md
# Lane Training Symbol Generator

This block produces the symbol stream for one lane of a DisplayPort-style transmitter. It sits in front of the 8b/10b encoder and outputs one 9-bit symbol per clock. Bit 8 of the symbol is the control (K) flag and bits 7:0 are the data byte. A 2-bit mode input selects what the lane carries:

- mode 00: the first training pattern.
- mode 01: the second training sequence.
- mode 10: an idle sequence.
- mode 11: pixel symbols passed through from one of two upstream pipes, called A and B.

Mode changes follow the mode input at the next clock edge, with one exception. A second training sequence that has started always runs to the end of its ten symbols before the block honours a new mode. When the last second-training sequence finishes, the block pulses a strobe. This strobe starts scrambler initialisation and resets running disparity downstream.

A port-enable bit and a pipe-select bit are written into a staging register. They only reach the live configuration on a vertical-blanking pulse, so that a frame is never cut mid-line. While the port is disabled, the lane is quiet: the output enable is low and the symbol is zero.

Top module: `lane_pattern_gen`

## Requirements
- R1: After a synchronous active-low reset, the block is in this state: port disabled (`lane_oe_o`=0, `sym_o`=0x000, both ready outputs low), pipe A selected, mode 00 active, and all sequence counters cleared. Once the port is enabled, mode 00 output appears without any further set-up.
- R2: With mode 00 active and the port enabled, `sym_o` is 0x04A (D10.2, K=0) on every cycle.
- R3: Mode 01 outputs a ten-symbol loop in this order: 0x1BC, 0x0CB, 0x1BC, 0x0CB, then 0x04A six times. The loop restarts whenever 01 is still requested at its end. A mode request made in the middle of the loop only takes effect after the symbol at index 9 has been sent.
- R4: `scr_init_o` is high for exactly one cycle. That cycle is the first cycle of the new mode after a mode 01 loop ends and a mode other than 01 follows. The strobe does not fire when the loop wraps into another loop.
- R5: Entering mode 10 starts the idle sequence: five pairs of 0x1BC followed by 0x008. The 0x008 byte is the VB-ID with bit 3, the no-video-stream flag, set. After the five pairs the block sends 0x000 fill symbols. Leaving mode 10 and coming back to it restarts the sequence at its first pair.
- R6: In mode 11, `sym_o` shows the selected pipe's data input in the same cycle while that pipe's valid input is high. It shows 0x000 while that pipe's valid input is low.
- R7: `cfg_wr_i` stores `cfg_enable_i` and `cfg_pipe_i` (0 = A, 1 = B) in a staging register, and the live setting changes only on a `vblank_i` pulse. A write made in the same cycle as the pulse takes effect on that pulse.
- R8: While the live port enable is 0, `lane_oe_o` is 0, `sym_o` is 0x000, and both ready outputs are low, whatever the mode.
- R9: A ready output is high only for the selected pipe, only in mode 11, and only while the port is enabled. The other pipe's valid and data inputs have no effect on `sym_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Requested lane mode |
| cfg_wr_i | input | 1 | Stage the enable and pipe-select values |
| cfg_enable_i | input | 1 | Port enable value to stage |
| cfg_pipe_i | input | 1 | Pipe select value to stage (0 = A, 1 = B) |
| vblank_i | input | 1 | Vertical-blanking pulse; applies the staged values |
| pipe_a_valid_i | input | 1 | Pipe A symbol valid |
| pipe_a_data_i | input | 9 | Pipe A symbol (K flag + byte) |
| pipe_a_ready_o | output | 1 | Lane accepts pipe A symbols |
| pipe_b_valid_i | input | 1 | Pipe B symbol valid |
| pipe_b_data_i | input | 9 | Pipe B symbol (K flag + byte) |
| pipe_b_ready_o | output | 1 | Lane accepts pipe B symbols |
| sym_o | output | 9 | Lane symbol to the encoder |
| lane_oe_o | output | 1 | Lane output enable (low = tristated) |
| scr_init_o | output | 1 | Scrambler and disparity initialise strobe |

## Verification
The bench walks through all sixteen ordered pairs of modes. Each source mode is held for a different length, so a request to leave mode 01 arrives at many different positions within the ten-symbol loop. This separates a correct hold-until-complete from a switch that happens early or late, and it separates a strobe on the real end of training from a strobe on a wrap. Pass-through runs with changing pipe data and a toggling valid on both pipes, which shows whether the unselected pipe leaks into the output. Enable and pipe writes are placed before a blanking pulse and on the same cycle as one, so that an early apply and a lost write each produce a different, visible error. The idle sequence is left and entered again to confirm that it restarts at its first pair.

// File: rtl/lpg_pkg.sv
// Package: shared types and symbol constants for the lane pattern generator.
// Assumes symbols are 9 bits: bit 8 = control flag, bits 7:0 = byte.
package lpg_pkg;

    localparam int DATA_W = 8;
    localparam int SYM_W  = DATA_W + 1;

    typedef enum logic [1:0] {
        MODE_TPS1 = 2'b00,
        MODE_TPS2 = 2'b01,
        MODE_IDLE = 2'b10,
        MODE_PASS = 2'b11
    } lane_mode_e;

    localparam logic [SYM_W-1:0] SYM_D10_2 = 9'h04A;
    localparam logic [SYM_W-1:0] SYM_D11_6 = 9'h0CB;
    localparam logic [SYM_W-1:0] SYM_K28_5 = 9'h1BC;
    localparam logic [SYM_W-1:0] SYM_D0_0  = 9'h000;
    localparam int               VBID_NOVIDEO_BIT = 3;
    localparam logic [SYM_W-1:0] SYM_VBID_IDLE = SYM_W'(1) << VBID_NOVIDEO_BIT;

    // Second training loop: alternating head of this many symbols, then D10.2.
    localparam int TPS2_LEN  = 10;
    localparam int TPS2_HEAD = 4;

endpackage

// File: rtl/lpg_stage_cfg.sv
// Module: lpg_stage_cfg
// Holds the staged and live copies of the port-enable and pipe-select bits.
// A write only lands in the staging copy; the vblank pulse moves the staged
// copy, or a write made on that same cycle, into the live copy.
// Assumes vblank_i is a single-cycle pulse in the clk domain.
module lpg_stage_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr_i,
    input  logic cfg_enable_i,
    input  logic cfg_pipe_i,
    input  logic vblank_i,
    output logic port_en_o,
    output logic pipe_sel_o
);

    logic pend_en_q, pend_pipe_q;
    logic live_en_q, live_pipe_q;

    // Staging copy: capture every configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_en_q   <= 1'b0;
            pend_pipe_q <= 1'b0;
        end else if (cfg_wr_i) begin
            pend_en_q   <= cfg_enable_i;
            pend_pipe_q <= cfg_pipe_i;
        end
    end

    // Live copy: apply on vblank, letting a same-cycle write through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_en_q   <= 1'b0;
            live_pipe_q <= 1'b0;
        end else if (vblank_i) begin
            live_en_q   <= cfg_wr_i ? cfg_enable_i : pend_en_q;
            live_pipe_q <= cfg_wr_i ? cfg_pipe_i   : pend_pipe_q;
        end
    end

    assign port_en_o  = live_en_q;
    assign pipe_sel_o = live_pipe_q;

    // R7: live settings never move between vblank pulses.
    a_r7_live_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank_i |=> $stable(live_en_q));
    a_r7_live_pipe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank_i |=> $stable(live_pipe_q));

endmodule

// File: rtl/lpg_seq.sv
// Module: lpg_seq
// Mode and position sequencer. Tracks the active mode and the index within
// the current pattern, holds a mode request while a second-training loop is
// unfinished, and produces the pattern symbol for the three generated modes.
// Assumes mode_i may change on any cycle; pass-through symbol is chosen outside.
module lpg_seq
    import lpg_pkg::*;
#(
    parameter int IDLE_PAIRS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lane_mode_e       mode_req_i,
    output lane_mode_e       mode_o,
    output logic [SYM_W-1:0] pat_sym_o,
    output logic             scr_init_o
);

    localparam int IDLE_LEN = 2 * IDLE_PAIRS;
    localparam int SEQ_MAX  = (IDLE_LEN > TPS2_LEN) ? IDLE_LEN : TPS2_LEN;
    localparam int IDX_W    = $clog2(SEQ_MAX + 1);
    localparam logic [IDX_W-1:0] TPS2_LAST = IDX_W'(TPS2_LEN - 1);
    localparam logic [IDX_W-1:0] IDLE_END  = IDX_W'(IDLE_LEN);
    localparam logic [IDX_W-1:0] HEAD_END  = IDX_W'(TPS2_HEAD);

    lane_mode_e       mode_q;
    logic [IDX_W-1:0] idx_q;
    logic             scr_q;
    logic             tps2_busy;

    assign tps2_busy = (mode_q == MODE_TPS2) && (idx_q != TPS2_LAST);

    // Mode and index advance; mid-loop requests wait for the loop to finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_TPS1;
            idx_q  <= '0;
            scr_q  <= 1'b0;
        end else begin
            scr_q <= (mode_q == MODE_TPS2) && !tps2_busy && (mode_req_i != MODE_TPS2);
            if (tps2_busy) begin
                idx_q <= idx_q + 1'b1;
            end else begin
                mode_q <= mode_req_i;
                if (mode_req_i == MODE_IDLE && mode_q == MODE_IDLE)
                    idx_q <= (idx_q == IDLE_END) ? idx_q : idx_q + 1'b1;
                else
                    idx_q <= '0;
            end
        end
    end

    // Pattern symbol for the active mode and index.
    always_comb begin
        unique case (mode_q)
            MODE_TPS2: pat_sym_o = (idx_q < HEAD_END)
                                 ? (idx_q[0] ? SYM_D11_6 : SYM_K28_5) : SYM_D10_2;
            MODE_IDLE: pat_sym_o = (idx_q < IDLE_END)
                                 ? (idx_q[0] ? SYM_VBID_IDLE : SYM_K28_5) : SYM_D0_0;
            MODE_PASS: pat_sym_o = SYM_D0_0;
            default:   pat_sym_o = SYM_D10_2;
        endcase
    end

    assign mode_o     = mode_q;
    assign scr_init_o = scr_q;

    // R3: an unfinished second-training loop keeps its mode next cycle.
    a_r3_loop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TPS2 && idx_q != TPS2_LAST) |=> (mode_q == MODE_TPS2));
    // R4: the strobe lasts one cycle and follows a second-training loop.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        scr_q |=> !scr_q);
    a_r4_after_tps2: assert property (@(posedge clk) disable iff (!rst_n)
        scr_q |-> ($past(mode_q) == MODE_TPS2 && mode_q != MODE_TPS2));

endmodule

// File: rtl/lpg_out_mux.sv
// Module: lpg_out_mux
// Chooses the lane symbol: quiet when disabled, pipe data in pass-through,
// the generated pattern otherwise. Drives per-pipe ready.
// Assumes pipe inputs are packed as arrays indexed by the pipe-select value.
module lpg_out_mux
    import lpg_pkg::*;
#(
    parameter int NUM_PIPES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             port_en_i,
    input  logic [$clog2(NUM_PIPES)-1:0]     pipe_sel_i,
    input  lane_mode_e                       mode_i,
    input  logic [SYM_W-1:0]                 pat_sym_i,
    input  logic [NUM_PIPES-1:0]             pipe_valid_i,
    input  logic [NUM_PIPES-1:0][SYM_W-1:0]  pipe_data_i,
    output logic [NUM_PIPES-1:0]             pipe_ready_o,
    output logic [SYM_W-1:0]                 sym_o,
    output logic                             lane_oe_o
);

    logic pass_on;
    assign pass_on = port_en_i && (mode_i == MODE_PASS);

    // Per-pipe ready: only the selected pipe in live pass-through.
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_ready
        assign pipe_ready_o[p] = pass_on && (pipe_sel_i == p);
    end

    // Lane symbol selection.
    always_comb begin
        if (!port_en_i)
            sym_o = SYM_D0_0;
        else if (mode_i == MODE_PASS)
            sym_o = pipe_valid_i[pipe_sel_i] ? pipe_data_i[pipe_sel_i] : SYM_D0_0;
        else
            sym_o = pat_sym_i;
    end

    assign lane_oe_o = port_en_i;

    // R9: at most one pipe sees ready.
    a_r9_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pipe_ready_o));

endmodule

// File: rtl/lane_pattern_gen.sv
// Module: lane_pattern_gen (top)
// Per-lane training and pixel symbol source ahead of an 8b/10b encoder.
// Joins the staged configuration, the mode sequencer and the output mux.
// Assumes a single clock domain and that vblank_i is a one-cycle pulse.
module lane_pattern_gen
    import lpg_pkg::*;
#(
    parameter int IDLE_PAIRS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_enable_i,
    input  logic             cfg_pipe_i,
    input  logic             vblank_i,
    input  logic             pipe_a_valid_i,
    input  logic [8:0]       pipe_a_data_i,
    output logic             pipe_a_ready_o,
    input  logic             pipe_b_valid_i,
    input  logic [8:0]       pipe_b_data_i,
    output logic             pipe_b_ready_o,
    output logic [8:0]       sym_o,
    output logic             lane_oe_o,
    output logic             scr_init_o
);

    localparam int NUM_PIPES = 2;

    logic                            port_en, pipe_sel;
    lane_mode_e                      act_mode;
    logic [SYM_W-1:0]                pat_sym;
    logic [NUM_PIPES-1:0]            valid_v, ready_v;
    logic [NUM_PIPES-1:0][SYM_W-1:0] data_v;

    assign valid_v = {pipe_b_valid_i, pipe_a_valid_i};
    assign data_v  = {pipe_b_data_i, pipe_a_data_i};
    assign pipe_a_ready_o = ready_v[0];
    assign pipe_b_ready_o = ready_v[1];

    lpg_stage_cfg i_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_enable_i (cfg_enable_i),
        .cfg_pipe_i   (cfg_pipe_i),
        .vblank_i     (vblank_i),
        .port_en_o    (port_en),
        .pipe_sel_o   (pipe_sel)
    );

    lpg_seq #(.IDLE_PAIRS(IDLE_PAIRS)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_req_i (lane_mode_e'(mode_i)),
        .mode_o     (act_mode),
        .pat_sym_o  (pat_sym),
        .scr_init_o (scr_init_o)
    );

    lpg_out_mux #(.NUM_PIPES(NUM_PIPES)) i_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_en_i    (port_en),
        .pipe_sel_i   (pipe_sel),
        .mode_i       (act_mode),
        .pat_sym_i    (pat_sym),
        .pipe_valid_i (valid_v),
        .pipe_data_i  (data_v),
        .pipe_ready_o (ready_v),
        .sym_o        (sym_o),
        .lane_oe_o    (lane_oe_o)
    );

    // R8: a disabled port is silent at the lane pins.
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (sym_o == 9'h000 && !pipe_a_ready_o && !pipe_b_ready_o));

endmodule

// File: tb/test_lane_pattern_gen.sv
// Bench: tracks the expected mode, index and live configuration from the
// requirements and compares every output after each clock edge.
module test_lane_pattern_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_r = 2'b00;
    logic       cfg_wr = 1'b0, cfg_en = 1'b0, cfg_pipe = 1'b0, vblank = 1'b0;
    logic       a_valid = 1'b0, b_valid = 1'b0;
    logic [8:0] a_data = 9'h0, b_data = 9'h0;
    logic       a_ready, b_ready, lane_oe, scr_init;
    logic [8:0] sym;

    int checks = 0, errors = 0;
    int m_mode = 0, m_pos = 0;
    bit m_en = 0, m_pipe = 0, p_en = 0, p_pipe = 0, m_scr = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    lane_pattern_gen i_lane_pattern_gen (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_r),
        .cfg_wr_i(cfg_wr), .cfg_enable_i(cfg_en), .cfg_pipe_i(cfg_pipe),
        .vblank_i(vblank),
        .pipe_a_valid_i(a_valid), .pipe_a_data_i(a_data), .pipe_a_ready_o(a_ready),
        .pipe_b_valid_i(b_valid), .pipe_b_data_i(b_data), .pipe_b_ready_o(b_ready),
        .sym_o(sym), .lane_oe_o(lane_oe), .scr_init_o(scr_init)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_sym();
        if (!m_en) return 'h000;
        case (m_mode)
            0: return 'h04A;
            1: return (m_pos < 4) ? ((m_pos % 2) ? 'h0CB : 'h1BC) : 'h04A;
            2: return (m_pos < 10) ? ((m_pos % 2) ? 'h008 : 'h1BC) : 'h000;
            default: begin
                if (m_pipe) return b_valid ? int'(b_data) : 'h000;
                return a_valid ? int'(a_data) : 'h000;
            end
        endcase
    endfunction

    function automatic string tag();
        if (!m_en) return "R8";
        case (m_mode)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One clock: update the expectation from the driven inputs, then compare.
    task automatic tick();
        m_scr = (m_mode == 1 && m_pos == 9 && mode_r != 2'd1);
        if (m_mode == 1 && m_pos != 9) m_pos++;
        else begin
            if (mode_r == 2'd2 && m_mode == 2) m_pos = (m_pos < 10) ? m_pos + 1 : 10;
            else m_pos = 0;
            m_mode = int'(mode_r);
        end
        if (vblank) begin
            m_en   = cfg_wr ? cfg_en   : p_en;
            m_pipe = cfg_wr ? cfg_pipe : p_pipe;
        end
        if (cfg_wr) begin p_en = cfg_en; p_pipe = cfg_pipe; end
        @(posedge clk); #1;
        chk(tag(), sym, exp_sym());
        chk(m_en ? "R1 oe" : "R8 oe", lane_oe, m_en);
        chk("R9 ready A", a_ready, m_en && m_mode == 3 && !m_pipe);
        chk("R9 ready B", b_ready, m_en && m_mode == 3 && m_pipe);
        chk("R4 strobe", scr_init, m_scr);
        cfg_wr = 1'b0; vblank = 1'b0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        a_valid = lfsr[0]; b_valid = lfsr[3];
        a_data = lfsr[8:0]; b_data = lfsr[15:7];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(2_000_000);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 oe", lane_oe, 0);
        chk("R1 sym", sym, 'h000);
        chk("R1 ready", {a_ready, b_ready}, 0);
        rst_n = 1'b1;
        // R7: staged enable does not act before vblank
        cfg_wr = 1; cfg_en = 1; cfg_pipe = 0;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R7 held", lane_oe, 0);
        end
        vblank = 1;
        tick();
        chk("R1 enabled D10.2", sym, 'h04A);
        // Sweep every ordered pair of modes with varied hold lengths.
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                mode_r = 2'(a);
                for (int i = 0; i < 12 + (a * 4 + b) % 10; i++) tick();
                mode_r = 2'(b);
                for (int i = 0; i < 14; i++) tick();
            end
        end
        // R7/R9: switch to pipe B at vblank only.
        mode_r = 2'd3;
        cfg_wr = 1; cfg_en = 1; cfg_pipe = 1;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R9 still A", {b_ready, a_ready}, 2'b01);
        end
        vblank = 1;
        tick();
        chk("R7 pipe B live", {b_ready, a_ready}, 2'b10);
        for (int i = 0; i < 20; i++) tick();
        // R7: write and vblank on the same cycle.
        cfg_wr = 1; cfg_en = 1; cfg_pipe = 0; vblank = 1;
        tick();
        chk("R7 same-cycle", {b_ready, a_ready}, 2'b01);
        for (int i = 0; i < 20; i++) tick();
        // R8: disable during pass-through and training.
        cfg_wr = 1; cfg_en = 0; vblank = 1;
        tick();
        for (int m = 0; m < 4; m++) begin
            mode_r = 2'(m);
            for (int i = 0; i < 12; i++) tick();
        end
        cfg_wr = 1; cfg_en = 1; cfg_pipe = 1; vblank = 1;
        tick();
        // R5: idle re-entry restarts the pairs.
        mode_r = 2'd2;
        for (int i = 0; i < 15; i++) tick();
        mode_r = 2'd0;
        tick();
        mode_r = 2'd2;
        tick();
        chk("R5 restart", sym, 'h1BC);
        for (int i = 0; i < 12; i++) tick();
        // R3/R4: loop wraps twice, then exits.
        mode_r = 2'd1;
        for (int i = 0; i < 25; i++) tick();
        mode_r = 2'd3;
        for (int i = 0; i < 12; i++) tick();
        finish_run();
    end

endmodule